// File: doc/BRIEF.md
# Windowed Watchdog with Reset-Time Configuration

This block is a watchdog timer whose complete setup comes from a single 8-bit configuration byte. The byte is captured once, on the first clock after reset is released, and stays fixed until the next reset. It selects whether the watchdog runs, how many count-clock ticks make up one overflow period, and what share of the period at its end accepts a restart. It also selects whether the low-speed count clock may be halted by the halt and stop modes or by a software stop request.

Counting advances on a count-clock enable tick. Software restarts the watchdog with a strobe that carries a key value. A restart is accepted only when the key is correct and the window is open. An accepted restart clears the counter and begins a new period. A wrong key, an early restart or an overflow produces a one-cycle reset request. Status outputs show whether the watchdog is active, whether the window is open, and whether the captured byte holds an illegal combination.

Top module: `win_wdog`

## Requirements
- R1: The configuration byte is captured on the first clock edge after reset is released. Later changes on `cfg_byte` have no effect until the next reset.
- R2: Bits 3..1 (select s) give a period P = 2^(10+s) ticks. With no restart, the P-th counted tick after the counter was cleared makes `wdt_rst` high in the following cycle.
- R3: Bits 6..5 (w) set the open window to the last (w+1)/4 of the period. `win_open` is 1 exactly when the counter value is at least (3-w)*P/4.
- R4: A restart with key 0xAC while `win_open` is 1 raises no reset and clears the counter to zero.
- R5: A restart while `win_open` is 0 makes `wdt_rst` high in the cycle after the strobe.
- R6: A restart whose key differs from 0xAC makes `wdt_rst` high in the cycle after the strobe.
- R7: When bit 4 (enable) is 0, the counter does not run, `active` is 0, and neither restarts nor ticks ever raise `wdt_rst`. When bit 4 is 1, `active` is 1 after capture.
- R8: `cfg_err` is 1 when the captured byte has bit 7 set, or when it has select 000 together with window 00. Otherwise it is 0.
- R9: When bit 0 (lock) is 0, ticks are not counted while `halt_mode`, `stop_mode` or `clk_stop_req` is 1. When bit 0 is 1, these inputs have no effect on counting.
- R10: `wdt_rst` is high for exactly one cycle per event, and the counter is zero in the cycle where it is high.
- R11: While `rst_n` is low, `wdt_rst`, `win_open`, `active` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_byte | input | 8 | Configuration byte, captured after reset |
| tick | input | 1 | Count-clock enable, one tick per cycle when high |
| kick | input | 1 | Restart strobe |
| kick_key | input | 8 | Key carried with the restart strobe |
| halt_mode | input | 1 | Halt mode indication |
| stop_mode | input | 1 | Stop mode indication |
| clk_stop_req | input | 1 | Software request to stop the count clock |
| wdt_rst | output | 1 | One-cycle reset request |
| win_open | output | 1 | Restart window is open |
| active | output | 1 | Watchdog is configured and enabled |
| cfg_err | output | 1 | Captured configuration is illegal |

## Verification
Some properties are checked on every cycle. These are the single-cycle reset pulse and the cleared window in that pulse cycle, the reset that follows a bad key or an early restart, the reset on reaching the last count, and the frozen counter while the clock is gated with lock off. They also cover the silence of a disabled watchdog and the persistence of the captured setup. Other behaviour can only be shown by the bench's scenarios. That covers the exact tick at which overflow falls for a chosen period, the window boundary for each of the four window encodings, and the fact that a later change of the byte leaves behaviour untouched. It also covers the difference that the lock bit makes under halt, stop and the stop request.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
  localparam int CFG_W = 8;
  localparam int SEL_W = 3;
  localparam int WIN_W = 2;

  // Field order is fixed: the position of each field is part of the byte's meaning
  typedef struct packed {
    logic             rsvd;
    logic [WIN_W-1:0] win;
    logic             en;
    logic [SEL_W-1:0] sel;
    logic             lock;
  } wdog_cfg_t;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_CLEAR = 2'd1,
    EV_FIRE  = 2'd2
  } wdog_ev_e;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import win_wdog_pkg::*;
#(
  parameter int MIN_EXP = 10,
  parameter int CNT_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_byte,
  output logic             cfg_valid,
  output logic             cfg_en,
  output logic             cfg_lock,
  output logic [CNT_W-1:0] period_last,
  output logic [CNT_W-1:0] closed_len,
  output logic             cfg_err
);
  wdog_cfg_t cfg_q, cfg_d;
  logic      valid_q, valid_d;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] quarter;

  always_comb begin
    valid_d = 1'b1;
    cfg_d   = valid_q ? cfg_q : wdog_cfg_t'(cfg_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end

  always_comb begin
    period      = (CNT_W+1)'(1) << (MIN_EXP + int'(cfg_q.sel));
    quarter     = CNT_W'(period >> 2);
    period_last = period[CNT_W-1:0] - CNT_W'(1);
    closed_len  = quarter * CNT_W'(2'd3 - cfg_q.win);
  end

  assign cfg_valid = valid_q;
  assign cfg_en    = valid_q & cfg_q.en;
  assign cfg_lock  = cfg_q.lock;
  assign cfg_err   = valid_q & (cfg_q.rsvd | ((cfg_q.sel == '0) && (cfg_q.win == '0)));
endmodule

// File: rtl/wdog_gate.sv
module wdog_gate (
  input  logic active,
  input  logic lock,
  input  logic tick,
  input  logic halt_mode,
  input  logic stop_mode,
  input  logic clk_stop_req,
  output logic frozen,
  output logic count_en
);
  always_comb begin
    frozen   = ~lock & (halt_mode | stop_mode | clk_stop_req);
    count_en = active & tick & ~frozen;
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import win_wdog_pkg::*;
#(
  parameter int              CNT_W = 17,
  parameter int              KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY  = 8'hAC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             count_en,
  input  logic             kick,
  input  logic [KEY_W-1:0] kick_key,
  input  logic [CNT_W-1:0] period_last,
  input  logic [CNT_W-1:0] closed_len,
  output logic             wdt_rst,
  output logic             win_open,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rst_q, rst_d;
  wdog_ev_e         ev;

  assign win_open = active & (cnt_q >= closed_len);

  always_comb begin
    ev = EV_NONE;
    if (active && kick) begin
      if ((kick_key != KEY) || !win_open) ev = EV_FIRE;
      else                                ev = EV_CLEAR;
    end else if (count_en && (cnt_q == period_last)) begin
      ev = EV_FIRE;
    end
  end

  always_comb begin
    unique case (ev)
      EV_FIRE, EV_CLEAR: cnt_d = '0;
      default:           cnt_d = count_en ? cnt_q + CNT_W'(1) : cnt_q;
    endcase
    rst_d = (ev == EV_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign wdt_rst = rst_q;
  assign cnt     = cnt_q;
endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int               MIN_EXP     = 10,
  parameter int               KEY_W       = 8,
  parameter logic [KEY_W-1:0] KEY         = 8'hAC,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic             tick,
  input  logic             kick,
  input  logic [KEY_W-1:0] kick_key,
  input  logic             halt_mode,
  input  logic             stop_mode,
  input  logic             clk_stop_req,
  output logic             wdt_rst,
  output logic             win_open,
  output logic             active,
  output logic             cfg_err
);
  localparam int CNT_W = MIN_EXP + (1 << SEL_W) - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   rst_ns;
  logic                   cfg_valid, cfg_en, cfg_lock, frozen, count_en;
  logic [CNT_W-1:0]       period_last, closed_len, cnt;

  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ns = sync_q[SYNC_STAGES-1];

  wdog_cfg #(.MIN_EXP(MIN_EXP), .CNT_W(CNT_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_ns),
    .cfg_byte    (cfg_byte),
    .cfg_valid   (cfg_valid),
    .cfg_en      (cfg_en),
    .cfg_lock    (cfg_lock),
    .period_last (period_last),
    .closed_len  (closed_len),
    .cfg_err     (cfg_err)
  );

  wdog_gate u_gate (
    .active       (cfg_en),
    .lock         (cfg_lock),
    .tick         (tick),
    .halt_mode    (halt_mode),
    .stop_mode    (stop_mode),
    .clk_stop_req (clk_stop_req),
    .frozen       (frozen),
    .count_en     (count_en)
  );

  wdog_core #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)) u_core (
    .clk         (clk),
    .rst_n       (rst_ns),
    .active      (cfg_en),
    .count_en    (count_en),
    .kick        (kick),
    .kick_key    (kick_key),
    .period_last (period_last),
    .closed_len  (closed_len),
    .wdt_rst     (wdt_rst),
    .win_open    (win_open),
    .cnt         (cnt)
  );

  assign active = cfg_en;
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
  parameter int               CNT_W = 17,
  parameter int               KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY   = 8'hAC
) (
  input logic             clk,
  input logic             rst_ns,
  input logic             active,
  input logic             lock,
  input logic             tick,
  input logic             kick,
  input logic [KEY_W-1:0] kick_key,
  input logic             halt_mode,
  input logic             stop_mode,
  input logic             clk_stop_req,
  input logic             win_open,
  input logic             wdt_rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period_last,
  input logic [CNT_W-1:0] closed_len
);
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    wdt_rst |=> !wdt_rst); // R10

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    (wdt_rst && (closed_len != '0)) |-> !win_open); // R10

  AST_KICK_CLOSED: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && kick && !win_open) |=> wdt_rst); // R5

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && kick && (kick_key != KEY)) |=> wdt_rst); // R6

  AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && tick && !kick && (lock || !(halt_mode || stop_mode || clk_stop_req))
     && (cnt == period_last)) |=> wdt_rst); // R2

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    !active |=> !wdt_rst); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    active |=> active); // R1

  AST_GATED_FROZEN: assert property (@(posedge clk) disable iff (!rst_ns)
    (active && !lock && (halt_mode || stop_mode || clk_stop_req) && !kick) |=> $stable(cnt)); // R9
endmodule

bind win_wdog win_wdog_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W), .KEY(KEY)) u_chk (
  .clk          (clk),
  .rst_ns       (rst_ns),
  .active       (cfg_en),
  .lock         (cfg_lock),
  .tick         (tick),
  .kick         (kick),
  .kick_key     (kick_key),
  .halt_mode    (halt_mode),
  .stop_mode    (stop_mode),
  .clk_stop_req (clk_stop_req),
  .win_open     (win_open),
  .wdt_rst      (wdt_rst),
  .cnt          (cnt),
  .period_last  (period_last),
  .closed_len   (closed_len)
);

// File: tb/win_wdog_tb_top.sv
module win_wdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, tick, kick, halt_mode, stop_mode, clk_stop_req;
  logic [7:0] cfg_byte, kick_key;
  logic       wdt_rst, win_open, active, cfg_err;

  int checks = 0;
  int failures = 0;
  int rst_seen = 0;
  bit done = 0;

  win_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .tick(tick), .kick(kick),
    .kick_key(kick_key), .halt_mode(halt_mode), .stop_mode(stop_mode),
    .clk_stop_req(clk_stop_req), .wdt_rst(wdt_rst), .win_open(win_open),
    .active(active), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (wdt_rst === 1'b1) rst_seen++;

  typedef struct packed {
    logic [7:0]  cfg;
    logic [15:0] n;
    logic [7:0]  key;
    logic        exp_open;
    logic        exp_rst;
    logic [7:0]  req;
  } vec_t;

  // cfg: bit6..5 window, bit4 enable, bits3..1 select, bit0 lock
  localparam vec_t VECS [9] = '{
    '{8'h71, 16'd5,    8'hAC, 1'b1, 1'b0, 8'd4},
    '{8'h12, 16'd1535, 8'hAC, 1'b0, 1'b1, 8'd5},
    '{8'h12, 16'd1536, 8'hAC, 1'b1, 1'b0, 8'd4},
    '{8'h32, 16'd1023, 8'hAC, 1'b0, 1'b1, 8'd5},
    '{8'h32, 16'd1024, 8'hAC, 1'b1, 1'b0, 8'd4},
    '{8'h50, 16'd255,  8'hAC, 1'b0, 1'b1, 8'd5},
    '{8'h50, 16'd256,  8'hAC, 1'b1, 1'b0, 8'd4},
    '{8'h71, 16'd5,    8'h53, 1'b1, 1'b1, 8'd6},
    '{8'h61, 16'd5,    8'h53, 1'b0, 1'b0, 8'd7}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [7:0] cfg);
    rst_n = 1'b0; cfg_byte = cfg; tick = 1'b0; kick = 1'b0; kick_key = 8'h00;
    halt_mode = 1'b0; stop_mode = 1'b0; clk_stop_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
  endtask

  task automatic tick_n(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    #1;
  endtask

  task automatic kick_do(input logic [7:0] key);
    kick = 1'b1; kick_key = key;
    @(posedge clk);
    @(negedge clk);
    kick = 1'b0;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    int r0;
    // R11: reset state
    rst_n = 1'b0; cfg_byte = 8'h10; tick = 1'b0; kick = 1'b0; kick_key = 8'h00;
    halt_mode = 1'b0; stop_mode = 1'b0; clk_stop_req = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R11 wdt_rst in reset", wdt_rst, 0);
    chk("R11 win_open in reset", win_open, 0);
    chk("R11 active in reset", active, 0);
    chk("R11 cfg_err in reset", cfg_err, 0);

    // vector table: window boundaries, keys, disabled
    foreach (VECS[i]) begin
      apply_reset(VECS[i].cfg);
      tick_n(int'(VECS[i].n));
      chk($sformatf("R3 window vector %0d", i), win_open, VECS[i].exp_open);
      kick_do(VECS[i].key);
      chk($sformatf("R%0d restart vector %0d", VECS[i].req, i), wdt_rst, VECS[i].exp_rst);
    end

    // R2: overflow timing, R10 pulse width
    apply_reset(8'h71);
    chk("R7 active when enabled", active, 1);
    r0 = rst_seen;
    tick_n(1023);
    chk("R2 no reset before last tick", rst_seen - r0, 0);
    tick_n(1);
    chk("R2 reset on P-th tick", wdt_rst, 1);
    step();
    chk("R10 pulse is one cycle", wdt_rst, 0);

    // R10: counter cleared by overflow pulse
    apply_reset(8'h50);
    tick_n(1024);
    chk("R2 overflow period 1024", wdt_rst, 1);
    chk("R10 window closed in pulse cycle", win_open, 0);
    step();
    kick_do(8'hAC);
    chk("R5 early restart after overflow", wdt_rst, 1);

    // R4: accepted restart clears the counter
    apply_reset(8'h50);
    tick_n(300);
    kick_do(8'hAC);
    chk("R4 accepted restart no reset", wdt_rst, 0);
    chk("R4 counter cleared closes window", win_open, 0);
    tick_n(255);
    chk("R3 window still closed at 255", win_open, 0);
    tick_n(1);
    chk("R3 window opens at 256", win_open, 1);

    // R9 lock off gating, R1 later byte ignored
    apply_reset(8'h50);
    cfg_byte = 8'h71;
    halt_mode = 1'b1;    tick_n(300); halt_mode = 1'b0;
    stop_mode = 1'b1;    tick_n(300); stop_mode = 1'b0;
    clk_stop_req = 1'b1; tick_n(300); clk_stop_req = 1'b0;
    chk("R9 gated ticks not counted", win_open, 0);
    tick_n(5);
    kick_do(8'hAC);
    chk("R1 later byte change ignored", wdt_rst, 1);

    // R9 lock on
    apply_reset(8'h51);
    halt_mode = 1'b1; clk_stop_req = 1'b1; stop_mode = 1'b1;
    tick_n(256);
    chk("R9 lock keeps counting", win_open, 1);
    halt_mode = 1'b0; clk_stop_req = 1'b0; stop_mode = 1'b0;

    // R8 configuration error
    apply_reset(8'h10);
    chk("R8 select0 window0 illegal", cfg_err, 1);
    apply_reset(8'hF1);
    chk("R8 reserved bit set", cfg_err, 1);
    apply_reset(8'h71);
    chk("R8 legal byte", cfg_err, 0);
    apply_reset(8'h12);
    chk("R8 window0 select1 legal", cfg_err, 0);

    // R7 disabled: no overflow
    apply_reset(8'h61);
    chk("R7 active when disabled", active, 0);
    r0 = rst_seen;
    tick_n(1100);
    kick_do(8'h00);
    step();
    chk("R7 disabled never resets", rst_seen - r0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule